// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

The block keeps a small set of recent page translations. A lookup gives a 32-bit virtual address together with the kind of access (read or write) and the privilege mode (user or kernel). Within the same cycle the block answers with exactly one of three results: a hit with the physical address, a miss, or a protection fault. Every stored tag is compared with the incoming virtual page number in parallel. On a hit, the 12-bit offset inside the 4 KB page passes through unchanged and is joined below the stored 20-bit physical page number.

A miss tells an external page walker to fetch the translation. The walker returns the translation on the refill stream (`fill_valid`/`fill_ready`). A transfer takes place on a rising edge where both are high. `fill_ready` is low only in a cycle where `flush` is high. In that cycle the offered fill is not taken, and the walker must hold it until `fill_ready` returns. A refill for a page that is already stored overwrites that slot. Otherwise it goes to the lowest free slot, and only when no slot is free does it replace the slot under a rotating FIFO pointer. `flush` empties the buffer in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every lookup misses.
- R2: A lookup whose page matches a valid entry and passes every check asserts `lk_hit` in the same cycle, with `lk_paddr` = {stored page number, `lk_vaddr[11:0]`}.
- R3: A lookup whose page matches no valid entry asserts `lk_miss`.
- R4: A user-mode lookup (`lk_user`=1) that matches an entry whose user bit is 0 asserts `lk_fault`. The same lookup in kernel mode hits.
- R5: A read that matches an entry with read permission 0 faults. A write that matches an entry with write permission 0 faults.
- R6: A permitted write that matches an entry whose dirty bit is 0 asserts `lk_miss` and not `lk_hit`. A read of that entry hits.
- R7: When `lk_valid` is 0, `lk_hit`, `lk_miss`, `lk_fault` and `lk_paddr` are all 0. At most one of the three flags is ever high.
- R8: A refill of a page not yet stored takes the lowest-numbered invalid slot while any slot is invalid.
- R9: With every slot valid, a refill of a new page replaces slots in FIFO order: slot 0 first, then slot 1, and so on, wrapping after the last. The pointer moves only when a valid slot is replaced.
- R10: A refill for a page that is already stored updates that slot in place. It consumes neither a free slot nor the FIFO pointer.
- R11: `flush` invalidates every entry and returns the FIFO pointer to slot 0 in one cycle. `fill_ready` is low while `flush` is high, and a fill offered in that cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_hit | output | 1 | Translation found and access allowed |
| lk_miss | output | 1 | No usable entry, or a clean page is being written |
| lk_fault | output | 1 | Access violates the entry's permissions |
| lk_paddr | output | 32 | Physical address, valid when `lk_hit` is high |
| fill_valid | input | 1 | Refill offered |
| fill_ready | output | 1 | Refill accepted this cycle |
| fill_vpn | input | 20 | Virtual page number of the refill |
| fill_ppn | input | 20 | Physical page number of the refill |
| fill_rd | input | 1 | Read permission |
| fill_wr | input | 1 | Write permission |
| fill_dirty | input | 1 | Page already dirty |
| fill_usr | input | 1 | Page accessible in user mode |
| flush | input | 1 | Invalidate all entries |

## Verification
The hardest condition to reach is FIFO replacement. It needs every slot valid, and it must hold both after an in-place update and after a flush has moved the pointer away from where the slot count alone would leave it. The stimulus therefore fills the buffer to exactly full around a rewritten page and confirms that no early eviction took place. It then forces two replacements. It flushes at a point where the pointer is at slot 2 and fills all slots plus one. Checking which page vanished exposes a pointer that advanced over free slots or that the flush did not reset.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int PPN_W = 20;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic             rd;
    logic             wr;
    logic             dirty;
    logic             usr;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N = 32
) (
  input  tlb_entry_t       ent [N],
  input  logic [N-1:0]     vld,
  input  logic [VPN_W-1:0] vpn,
  output logic [N-1:0]     match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = vld[i] && (ent[i].vpn == vpn);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0] vld,
  output logic         free_any,
  output logic [IW-1:0] free_idx
);
  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IW'(i);
    end
  end
  assign free_any = ~&vld;
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  tlb_entry_t ent,
  input  logic       is_write,
  input  logic       is_user,
  output logic       fault,
  output logic       clean_write
);
  always_comb begin
    fault = (is_user && !ent.usr) || (is_write ? !ent.wr : !ent.rd);
    clean_write = !fault && is_write && !ent.dirty;
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_write,
  input  logic              lk_user,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic [PA_W-1:0]   lk_paddr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              fill_rd,
  input  logic              fill_wr,
  input  logic              fill_dirty,
  input  logic              fill_usr,
  input  logic              flush
);
  localparam int IW = $clog2(ENTRIES);

  tlb_entry_t         ent [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [IW-1:0]      ptr;

  // lookup path
  logic [ENTRIES-1:0] lk_match;
  tlb_entry_t         sel;
  logic               any_match, perm_fault, clean_wr;

  tlb_match #(.N(ENTRIES)) u_lk_match (
    .ent(ent), .vld(vld), .vpn(lk_vaddr[VA_W-1:OFF_W]), .match(lk_match)
  );

  always_comb begin
    sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) sel = sel | ent[i];
    end
  end

  tlb_perm u_perm (
    .ent(sel), .is_write(lk_write), .is_user(lk_user),
    .fault(perm_fault), .clean_write(clean_wr)
  );

  assign any_match = |lk_match;
  assign lk_fault  = lk_valid && any_match && perm_fault;
  assign lk_hit    = lk_valid && any_match && !perm_fault && !clean_wr;
  assign lk_miss   = lk_valid && (!any_match || clean_wr);
  assign lk_paddr  = lk_hit ? {sel.ppn, lk_vaddr[OFF_W-1:0]} : '0;

  // refill path
  logic [ENTRIES-1:0] fl_match;
  logic               fl_present, free_any, fill_fire;
  logic [IW-1:0]      free_idx, fl_idx, tgt;

  tlb_match #(.N(ENTRIES)) u_fl_match (
    .ent(ent), .vld(vld), .vpn(fill_vpn), .match(fl_match)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .vld(vld), .free_any(free_any), .free_idx(free_idx)
  );

  always_comb begin
    fl_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fl_match[i]) fl_idx = IW'(i);
    end
  end

  assign fl_present = |fl_match;
  assign fill_ready = !flush;
  assign fill_fire  = fill_valid && fill_ready;
  assign tgt        = fl_present ? fl_idx : (free_any ? free_idx : ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
    end else if (flush) begin
      vld <= '0;
      ptr <= '0;
    end else if (fill_fire) begin
      vld[tgt] <= 1'b1;
      if (!fl_present && !free_any)
        ptr <= (ptr == IW'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush && fill_fire) begin
      ent[tgt] <= '{vpn: fill_vpn, ppn: fill_ppn, rd: fill_rd, wr: fill_wr,
                    dirty: fill_dirty, usr: fill_usr};
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             lk_write,
  input logic             lk_user,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_fault,
  input logic [PA_W-1:0]  lk_paddr,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [PPN_W-1:0] fill_ppn,
  input logic             fill_rd,
  input logic             flush
);
  // R7
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss, lk_fault}));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss && !lk_fault && lk_paddr == '0));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (lk_valid |-> lk_miss));

  // R11
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fill_ready);

  // R2
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready && fill_rd) |=>
      ((lk_valid && !lk_write && !lk_user &&
        lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)) |->
       (lk_hit && lk_paddr[PA_W-1:OFF_W] == $past(fill_ppn))));
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_write(lk_write), .lk_user(lk_user), .lk_hit(lk_hit), .lk_miss(lk_miss),
  .lk_fault(lk_fault), .lk_paddr(lk_paddr), .fill_valid(fill_valid),
  .fill_ready(fill_ready), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
  .fill_rd(fill_rd), .flush(flush)
);

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_miss, lk_fault, fill_ready;
  logic [31:0] lk_paddr;
  logic        fill_valid = 0, fill_rd = 0, fill_wr = 0, fill_dirty = 0, fill_usr = 0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic        flush = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tlb_xlate u_dut (.*);

  typedef struct {
    logic [1:0]  kind;   // 0 idle, 1 hit, 2 miss, 3 fault
    logic [31:0] pa;
    string       req;
  } exp_t;
  exp_t sb[$];

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic r, input logic w, input logic d, input logic u);
    @(negedge clk);
    lk_valid = 0;
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn;
    fill_rd = r; fill_wr = w; fill_dirty = d; fill_usr = u;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic w, input logic u,
                      input logic [1:0] kind, input logic [31:0] pa, input string req);
    exp_t e;
    @(negedge clk);
    lk_valid = (kind != 0); lk_vaddr = va; lk_write = w; lk_user = u;
    e.kind = kind; e.pa = pa; e.req = req;
    sb.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        logic [1:0] got;
        e = sb.pop_front();
        got = lk_hit ? 2'd1 : lk_miss ? 2'd2 : lk_fault ? 2'd3 : 2'd0;
        checks++;
        if (got != e.kind || (e.kind == 1 && lk_paddr != e.pa) ||
            (e.kind == 0 && lk_paddr != 0) ||
            (int'(lk_hit) + int'(lk_miss) + int'(lk_fault) > 1)) begin
          fails++;
          $display("FAIL %s: got kind=%0d pa=%h expected kind=%0d pa=%h",
                   e.req, got, lk_paddr, e.kind, e.pa);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    look(32'h0001_0123, 0, 0, 2, 0, "R1");
    look(32'hFFFF_F000, 1, 1, 2, 0, "R1");
    // R2: full rights
    fill(20'h00010, 20'hABCDE, 1, 1, 1, 1);
    look(32'h0001_0123, 0, 1, 1, 32'hABCD_E123, "R2");
    look(32'h0001_0FFF, 1, 0, 1, 32'hABCD_EFFF, "R2");
    // R3
    look(32'h0001_1000, 0, 0, 2, 0, "R3");
    // R4: kernel-only page
    fill(20'h00020, 20'h11111, 1, 1, 1, 0);
    look(32'h0002_0004, 0, 1, 3, 0, "R4");
    look(32'h0002_0004, 0, 0, 1, 32'h1111_1004, "R4");
    // R5
    fill(20'h00030, 20'h22222, 0, 1, 1, 1);
    look(32'h0003_0010, 0, 0, 3, 0, "R5");
    fill(20'h00031, 20'h33333, 1, 0, 1, 1);
    look(32'h0003_1010, 1, 0, 3, 0, "R5");
    look(32'h0003_1010, 0, 0, 1, 32'h3333_3010, "R5");
    // R6: clean page
    fill(20'h00040, 20'h44444, 1, 1, 0, 1);
    look(32'h0004_0020, 1, 1, 2, 0, "R6");
    look(32'h0004_0020, 0, 1, 1, 32'h4444_4020, "R6");
    // R10: in-place update marks dirty, new ppn
    fill(20'h00040, 20'h55555, 1, 1, 1, 1);
    look(32'h0004_0020, 1, 1, 1, 32'h5555_5020, "R10");
    // R7
    look(32'h0001_0123, 0, 0, 0, 0, "R7");
    // R8: fill remaining 27 slots; buffer now exactly full
    for (int i = 0; i < 27; i++) fill(20'h00100 + 20'(i), 20'h60000 + 20'(i), 1, 1, 1, 1);
    look(32'h0001_0000, 0, 0, 1, 32'hABCD_E000, "R10");
    look(32'h0011_A008, 0, 0, 1, 32'h6001_A008, "R8");
    // R9: FIFO replacement starts at slot 0
    fill(20'h00200, 20'h70000, 1, 1, 1, 1);
    look(32'h0001_0000, 0, 0, 2, 0, "R9");
    look(32'h0002_0000, 0, 0, 1, 32'h1111_1000, "R9");
    look(32'h0020_0abc, 0, 0, 1, 32'h7000_0abc, "R9");
    fill(20'h00201, 20'h70001, 1, 1, 1, 1);
    look(32'h0002_0000, 0, 0, 2, 0, "R9");
    look(32'h0003_1000, 0, 0, 1, 32'h3333_3000, "R9");
    // R11: flush with a concurrent fill offer
    @(negedge clk);
    flush = 1; fill_valid = 1; fill_vpn = 20'h00300; fill_ppn = 20'h0F0F0;
    fill_rd = 1; fill_wr = 1; fill_dirty = 1; fill_usr = 1;
    #1;
    checks++;
    if (fill_ready !== 1'b0) begin
      fails++;
      $display("FAIL R11: got fill_ready=%b expected 0", fill_ready);
    end
    @(negedge clk);
    flush = 0; fill_valid = 0;
    look(32'h0030_0000, 0, 0, 2, 0, "R11");
    look(32'h0003_1000, 0, 0, 2, 0, "R11");
    // R11/R8: pointer back at slot 0 after flush
    for (int i = 0; i < 33; i++) fill(20'h00400 + 20'(i), 20'h80000 + 20'(i), 1, 1, 1, 1);
    look(32'h0040_0000, 0, 0, 2, 0, "R11");
    look(32'h0040_1000, 0, 0, 1, 32'h8000_1000, "R11");
    look(32'h0042_0000, 0, 0, 1, 32'h8002_0000, "R8");
    look(32'h0, 0, 0, 0, 0, "R7");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule